// File: doc/BRIEF.md
# Decode-Stage Operand Forwarding and Load Stall Logic

This block sits in the decode stage of a five-stage in-order pipeline. It looks at the source register fields of the instruction being decoded and compares them with the destination register carried in the control words of the two older instructions, one in EXE and one in MEM. From that comparison it produces a 2-bit bypass select for each ALU operand.

If the instruction directly ahead is a load, its result is not yet available. In that case the block stalls the front end for one cycle: it drops the program-counter and instruction-register write enables and sends an all-zero control word into EXE as a bubble. The block also works out whether each source register is really read, using the operand-source flags in the decoded control word. That way immediates and shift amounts never cause false hazards.

The register file, ALU and bypass multiplexers are outside this block. It is purely combinational. Its clock and reset are used only by its embedded property checks.

Top module: `hazard_fwd_unit`

## Requirements
- R1: Each operand select is 2 bits. 00 selects the register-file value, 01 selects the ALU-result bypass, and 10 selects the MEM-stage pipeline register. The value 11 never occurs.
- R2: A control word marks a register-writing instruction with bit 8 set and gives its destination index in bits 13:9. If the EXE-stage instruction writes a register that a used source names, and bit 14 (result ready in EXE) of its word is set, that operand's select is 01.
- R3: If the EXE-stage instruction writes a register that a used source names, and its bit 14 is clear (a load), then `pc_we` and `ir_we` are both 0 for that cycle and `ex_ctrl_o` is all zeros.
- R4: If the MEM-stage instruction writes a register that a used source names, that operand's select is 10. This holds whatever the instruction's bits 14 and 15 are.
- R5: When both older instructions match the same operand, the EXE-stage instruction decides the result. The select is then 01, or 00 with a stall, and never 10.
- R6: A destination of register 0, or a control word with bit 8 clear, never produces a nonzero select or a stall.
- R7: The rs field is instruction bits 25:21 and is used only when decoded control bit 5 is 0; otherwise operand A is the shift amount. The rt field is bits 20:16 and is used when control bits 17:16 are 00 or when bit 6 (store) is 1. An unused field never causes forwarding or a stall.
- R8: When there is no stall, `pc_we` and `ir_we` are 1 and `ex_ctrl_o` equals `id_ctrl` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the embedded checks |
| rst_n | input | 1 | Active-low reset for the embedded checks |
| id_instr | input | 32 | Instruction in decode |
| id_ctrl | input | 32 | Control word decoded for that instruction |
| ex_ctrl | input | 32 | Control word of the instruction in EXE |
| mem_ctrl | input | 32 | Control word of the instruction in MEM |
| sel_a | output | 2 | Bypass select for ALU operand A |
| sel_b | output | 2 | Bypass select for ALU operand B |
| pc_we | output | 1 | Program counter write enable (0 = hold) |
| ir_we | output | 1 | Instruction register write enable (0 = hold) |
| ex_ctrl_o | output | 32 | Control word passed into EXE (zero on bubble) |

## Verification
The bench targets several corner cases:
- **Dual match.** Both older instructions hit the same source. A design with the wrong priority would bypass stale MEM data with select 10.
- **Register 0 and disabled writes.** Destinations of register 0 and words with the write bit clear must stay quiet. A careless comparator would stall or bypass on them.
- **Unused sources.** Operand fields selected away by the immediate, shift or store flags must be ignored. Getting this wrong shows up as spurious stalls on immediate instructions, or as missed store-data hazards.
- **Stalls.** On each stall the bench checks that the EXE control word is zeroed. A leaked word would let the bubble write a register.

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit #(
  parameter int CW = 32,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   id_instr,
  input  logic [CW-1:0] id_ctrl,
  input  logic [CW-1:0] ex_ctrl,
  input  logic [CW-1:0] mem_ctrl,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b,
  output logic          pc_we,
  output logic          ir_we,
  output logic [CW-1:0] ex_ctrl_o
);
  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_ALU = 2'b01;
  localparam logic [1:0] SEL_MEM = 2'b10;

  logic [RW-1:0] rs, rt, ex_dst, mem_dst;
  logic use_rs, use_rt, ex_wr, mem_wr, ex_early;
  logic hit1_a, hit1_b, hit2_a, hit2_b, stall;

  assign rs      = id_instr[25:21];
  assign rt      = id_instr[20:16];
  assign use_rs  = ~id_ctrl[5];
  assign use_rt  = (id_ctrl[17:16] == 2'b00) | id_ctrl[6];

  assign ex_dst  = ex_ctrl[13:9];
  assign mem_dst = mem_ctrl[13:9];
  assign ex_wr   = ex_ctrl[8]  & (ex_dst  != '0);
  assign mem_wr  = mem_ctrl[8] & (mem_dst != '0);
  assign ex_early = ex_ctrl[14];

  assign hit1_a = use_rs & ex_wr  & (ex_dst  == rs);
  assign hit1_b = use_rt & ex_wr  & (ex_dst  == rt);
  assign hit2_a = use_rs & mem_wr & (mem_dst == rs);
  assign hit2_b = use_rt & mem_wr & (mem_dst == rt);

  always_comb begin
    sel_a = SEL_RF;
    if (hit1_a)      sel_a = ex_early ? SEL_ALU : SEL_RF;
    else if (hit2_a) sel_a = SEL_MEM;
    sel_b = SEL_RF;
    if (hit1_b)      sel_b = ex_early ? SEL_ALU : SEL_RF;
    else if (hit2_b) sel_b = SEL_MEM;
  end

  assign stall     = (hit1_a | hit1_b) & ~ex_early;
  assign pc_we     = ~stall;
  assign ir_we     = ~stall;
  assign ex_ctrl_o = stall ? '0 : id_ctrl;

  p_sel_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a != 2'b11) && (sel_b != 2'b11));
  p_hold_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we == ir_we);
  p_bubble_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_we |-> (ex_ctrl_o == '0));
  p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_ctrl[8] && !mem_ctrl[8]) |-> (sel_a == 2'b00 && sel_b == 2'b00 && pc_we));
  p_unused_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (id_ctrl[5] && id_ctrl[17:16] != 2'b00 && !id_ctrl[6]) |->
      (sel_a == 2'b00 && sel_b == 2'b00 && pc_we));
  p_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |-> (ex_ctrl_o == id_ctrl));
endmodule

// File: tb/hazard_fwd_unit_tb.sv
module hazard_fwd_unit_tb_top;
  logic clk = 0, rst_n = 0;
  logic [31:0] id_instr = '0, id_ctrl = '0, ex_ctrl = '0, mem_ctrl = '0;
  logic [1:0] sel_a, sel_b;
  logic pc_we, ir_we;
  logic [31:0] ex_ctrl_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hazard_fwd_unit dut_i (.clk(clk), .rst_n(rst_n), .id_instr(id_instr), .id_ctrl(id_ctrl),
    .ex_ctrl(ex_ctrl), .mem_ctrl(mem_ctrl), .sel_a(sel_a), .sel_b(sel_b),
    .pc_we(pc_we), .ir_we(ir_we), .ex_ctrl_o(ex_ctrl_o));

  function automatic logic [31:0] mk_ctrl(bit wr, logic [4:0] dst, bit early, bit late,
                                         bit asrc, logic [1:0] bsrc, bit st);
    logic [31:0] c = '0;
    c[8] = wr; c[13:9] = dst; c[14] = early; c[15] = late;
    c[5] = asrc; c[17:16] = bsrc; c[6] = st;
    return c;
  endfunction

  function automatic logic [31:0] mk_instr(logic [4:0] s, logic [4:0] t);
    return {6'h0, s, t, 16'h1234};
  endfunction

  function automatic logic [2:0] ref_sel(logic [4:0] r, bit used, logic [31:0] e, logic [31:0] m);
    bit h1 = used && e[8] && e[13:9] != 0 && e[13:9] == r;
    bit h2 = used && m[8] && m[13:9] != 0 && m[13:9] == r;
    if (h1) return e[14] ? 3'b001 : 3'b100;
    if (h2) return 3'b010;
    return 3'b000;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply_and_check(string tag);
    logic [2:0] ra, rb;
    bit stl;
    @(negedge clk);
    #1;
    ra = ref_sel(id_instr[25:21], !id_ctrl[5], ex_ctrl, mem_ctrl);
    rb = ref_sel(id_instr[20:16], id_ctrl[17:16] == 0 || id_ctrl[6], ex_ctrl, mem_ctrl);
    stl = ra[2] | rb[2];
    check({tag, " sel_a"}, {30'b0, sel_a}, {30'b0, ra[1:0]});
    check({tag, " sel_b"}, {30'b0, sel_b}, {30'b0, rb[1:0]});
    check({tag, " pc_we"}, {31'b0, pc_we}, {31'b0, !stl});
    check({tag, " ir_we"}, {31'b0, ir_we}, {31'b0, !stl});
    check({tag, " ex_ctrl_o"}, ex_ctrl_o, stl ? 32'h0 : id_ctrl);
  endtask

  task automatic set(logic [31:0] i, logic [31:0] d, logic [31:0] e, logic [31:0] m);
    @(posedge clk);
    id_instr <= i; id_ctrl <= d; ex_ctrl <= e; mem_ctrl <= m;
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    apply_and_check("reset R1");
    repeat (3) @(posedge clk);
    rst_n <= 1;

    set(mk_instr(5'd3, 5'd7), mk_ctrl(1, 5'd9, 1, 0, 0, 2'b00, 0),
        mk_ctrl(1, 5'd3, 1, 0, 0, 2'b00, 0), '0);
    apply_and_check("R2 alu bypass rs");
    check("R2 direct", {30'b0, sel_a}, 32'd1);

    set(mk_instr(5'd3, 5'd7), mk_ctrl(1, 5'd9, 1, 0, 0, 2'b00, 0),
        mk_ctrl(1, 5'd7, 0, 1, 0, 2'b00, 0), '0);
    apply_and_check("R3 load stall");
    check("R3 direct", {31'b0, pc_we}, 32'd0);

    set(mk_instr(5'd3, 5'd7), mk_ctrl(1, 5'd9, 1, 0, 0, 2'b00, 0),
        '0, mk_ctrl(1, 5'd7, 0, 1, 0, 2'b00, 0));
    apply_and_check("R4 mem bypass");
    check("R4 direct", {30'b0, sel_b}, 32'd2);

    set(mk_instr(5'd4, 5'd7), mk_ctrl(1, 5'd9, 1, 0, 0, 2'b00, 0),
        mk_ctrl(1, 5'd4, 1, 0, 0, 2'b00, 0), mk_ctrl(1, 5'd4, 1, 0, 0, 2'b00, 0));
    apply_and_check("R5 priority");
    check("R5 direct", {30'b0, sel_a}, 32'd1);

    set(mk_instr(5'd0, 5'd0), mk_ctrl(1, 5'd9, 1, 0, 0, 2'b00, 0),
        mk_ctrl(1, 5'd0, 0, 1, 0, 2'b00, 0), mk_ctrl(1, 5'd0, 1, 0, 0, 2'b00, 0));
    apply_and_check("R6 reg0");
    check("R6 direct", {31'b0, pc_we}, 32'd1);

    set(mk_instr(5'd5, 5'd5), mk_ctrl(1, 5'd9, 1, 0, 0, 2'b00, 0),
        mk_ctrl(0, 5'd5, 0, 1, 0, 2'b00, 0), mk_ctrl(0, 5'd5, 1, 0, 0, 2'b00, 0));
    apply_and_check("R6 no write");

    set(mk_instr(5'd6, 5'd6), mk_ctrl(1, 5'd9, 1, 0, 1, 2'b01, 0),
        mk_ctrl(1, 5'd6, 0, 1, 0, 2'b00, 0), '0);
    apply_and_check("R7 unused");
    check("R7 direct", {31'b0, pc_we}, 32'd1);

    set(mk_instr(5'd6, 5'd6), mk_ctrl(0, 5'd0, 0, 0, 1, 2'b01, 1),
        '0, mk_ctrl(1, 5'd6, 1, 0, 0, 2'b00, 0));
    apply_and_check("R7 store rt");
    check("R7 store", {30'b0, sel_b}, 32'd2);

    set(mk_instr(5'd1, 5'd2), 32'hA5A5_0000, mk_ctrl(1, 5'd8, 1, 0, 0, 2'b00, 0), '0);
    apply_and_check("R8 pass");

    for (int k = 0; k < 3000; k++) begin
      set(mk_instr(5'($urandom_range(0, 3)), 5'($urandom_range(0, 3))),
          $urandom, ($urandom & 32'hFFFF_C1FF) | (32'($urandom_range(0, 3)) << 9),
          ($urandom & 32'hFFFF_C1FF) | (32'($urandom_range(0, 3)) << 9));
      apply_and_check("R5 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule